// File: doc/BRIEF.md
# Dual-Ratio Baud Rate Generator

This block derives a transmit bit-clock enable and a receive bit-clock enable from the system clock. A single reload down-counter is loaded from an 8-bit time constant N. It emits a one-cycle tick every N system clocks, and a constant of zero stands for 256. That tick feeds two free-running power-of-two dividers, one for each direction. Each divider has its own 4-bit exponent E, so its output fires once every N * 2^E system clocks.

Each direction also has a 3-bit clock-source select. Only the code assigned to the internal generator lets the divided enable reach the output. Any other code holds that output low, because the serial engine then takes its clock from elsewhere. All outputs are single-cycle enables in the system clock domain. There are no derived clocks.

Top module: `dual_baud_gen`

## Requirements
- R1: With time constant N in 1..255, the internal tick occurs exactly once every N system clocks. The first tick appears in the cycle that follows the N-th rising edge after reset is released.
- R2: A time constant of 0 produces one tick every 256 system clocks.
- R3: A time constant of 1 produces a tick on every system clock.
- R4: Each output enable is one system clock wide and fires once every N * 2^E clocks. The first pulse follows edge N * 2^E after reset, and the transmit and receive exponents act independently.
- R5: An exponent of 0 passes every tick straight to the output enable of that direction.
- R6: An exponent above 9 behaves exactly as an exponent of 9.
- R7: A new time constant written while the timer is counting does not shorten the current interval. It sets the length of the interval that starts at the next reload.
- R8: A clock-source select of 3'b010 selects the internal generator and lets the divided enable through. Any other select value holds that direction's enable low at all times.
- R9: A synchronous reset clears the timer and both dividers, so both enables are low while reset is held. After release, counting restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| time_const | input | 8 | Reload time constant N (0 means 256) |
| tx_exp | input | 4 | Transmit divide exponent E (values above 9 act as 9) |
| rx_exp | input | 4 | Receive divide exponent E (values above 9 act as 9) |
| tx_src | input | 3 | Transmit clock-source select (3'b010 = internal generator) |
| rx_src | input | 3 | Receive clock-source select (3'b010 = internal generator) |
| tx_clk_en | output | 1 | One-cycle transmit bit-clock enable |
| rx_clk_en | output | 1 | One-cycle receive bit-clock enable |

## Verification
The bench targets the following corner cases and the faults each one exposes:

- **Constant 0:** a timer that takes zero literally would either stall or tick every cycle, instead of ticking every 256 clocks.
- **Constant 1:** an off-by-one in the reload test would halve the rate instead of giving a solid tick.
- **Exponents above 9:** without the clamp, the divider mask would wrap and give a short or wrong period.
- **Time constant changed mid-count:** an eager reload would move the next tick early instead of leaving it at the end of the current interval.
- **Gated source codes and mid-run reset:** a design that ignores the source select would leak pulses through. A reset that clears only the timer would shift the first divided pulse away from edge N * 2^E.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int TC_W     = 8;
  localparam int CNT_W    = TC_W + 1;
  localparam int EXP_W    = 4;
  localparam int MAX_EXP  = 9;
  localparam int DIV_W    = MAX_EXP;
  localparam int SRC_W    = 3;
  localparam logic [SRC_W-1:0] SRC_INTERNAL = 3'b010;

  // Reload value: zero stands for the full 2^TC_W interval.
  function automatic logic [CNT_W-1:0] reload_value(input logic [TC_W-1:0] tc);
    if (tc == '0) return CNT_W'(1) << TC_W;
    return {1'b0, tc};
  endfunction

  // Exponent limited to MAX_EXP.
  function automatic logic [EXP_W-1:0] clamp_exp(input logic [EXP_W-1:0] e);
    if (int'(e) > MAX_EXP) return EXP_W'(MAX_EXP);
    return e;
  endfunction

  // Low-bit mask of the divider counter: 2^E - 1.
  function automatic logic [DIV_W-1:0] div_mask(input logic [EXP_W-1:0] e);
    logic [DIV_W:0] m;
    m = ((DIV_W+1)'(1) << clamp_exp(e)) - (DIV_W+1)'(1);
    return m[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/brg_reload_timer.sv
module brg_reload_timer
  import brg_pkg::*;
#(
  parameter int W  = TC_W,
  localparam int CW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  tc,
  output logic          tick,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q <= 1)   cnt_q <= CW'(reload_value(TC_W'(tc)));
    else                   cnt_q <= cnt_q - CW'(1);
  end

  assign tick  = (cnt_q == CW'(1));
  assign count = cnt_q;
endmodule

// File: rtl/brg_pow2_div.sv
module brg_pow2_div
  import brg_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [EW-1:0] exp_sel,
  output logic          pulse
);
  logic [DW-1:0] acc_q;
  logic [DW-1:0] mask;

  assign mask = DW'(div_mask(EXP_W'(exp_sel)));

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (tick) acc_q <= acc_q + DW'(1);
  end

  // Fires on the tick that rolls the low E bits back to zero.
  assign pulse = tick && ((acc_q & mask) == mask);
endmodule

// File: rtl/brg_src_gate.sv
module brg_src_gate
  import brg_pkg::*;
#(
  parameter int SW = SRC_W,
  parameter logic [SW-1:0] CODE = SW'(SRC_INTERNAL)
) (
  input  logic          en_in,
  input  logic [SW-1:0] src,
  output logic          en_out
);
  assign en_out = en_in && (src == CODE);
endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
  import brg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [TC_W-1:0]  time_const,
  input  logic [EXP_W-1:0] tx_exp,
  input  logic [EXP_W-1:0] rx_exp,
  input  logic [SRC_W-1:0] tx_src,
  input  logic [SRC_W-1:0] rx_src,
  output logic             tx_clk_en,
  output logic             rx_clk_en
);
  localparam int NCH = 2;

  logic             tmr_tick;
  logic [CNT_W-1:0] tmr_count;
  logic [EXP_W-1:0] ch_exp   [NCH];
  logic [SRC_W-1:0] ch_src   [NCH];
  logic             ch_pulse [NCH];
  logic             ch_en    [NCH];
  logic             tx_div_pulse;
  logic             rx_div_pulse;

  assign ch_exp[0] = tx_exp;
  assign ch_exp[1] = rx_exp;
  assign ch_src[0] = tx_src;
  assign ch_src[1] = rx_src;

  brg_reload_timer #(.W(TC_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .tc    (time_const),
    .tick  (tmr_tick),
    .count (tmr_count)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    brg_pow2_div #(.EW(EXP_W), .DW(DIV_W)) u_div (
      .clk     (clk),
      .rst     (rst),
      .tick    (tmr_tick),
      .exp_sel (ch_exp[c]),
      .pulse   (ch_pulse[c])
    );
    brg_src_gate #(.SW(SRC_W), .CODE(SRC_INTERNAL)) u_gate (
      .en_in  (ch_pulse[c]),
      .src    (ch_src[c]),
      .en_out (ch_en[c])
    );
  end

  assign tx_div_pulse = ch_pulse[0];
  assign rx_div_pulse = ch_pulse[1];
  assign tx_clk_en    = ch_en[0];
  assign rx_clk_en    = ch_en[1];
endmodule

// File: rtl/dual_baud_gen_chk.sv
module dual_baud_gen_chk
  import brg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [TC_W-1:0]  time_const,
  input logic [EXP_W-1:0] tx_exp,
  input logic [EXP_W-1:0] rx_exp,
  input logic [SRC_W-1:0] tx_src,
  input logic [SRC_W-1:0] rx_src,
  input logic             tx_clk_en,
  input logic             rx_clk_en,
  input logic             tmr_tick,
  input logic [CNT_W-1:0] tmr_count,
  input logic             tx_div_pulse,
  input logic             rx_div_pulse
);
  AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (rst)
    (tmr_count <= 1) |=> (int'(tmr_count) == (($past(time_const) == 0) ? 256 : int'($past(time_const))))); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (tmr_count > 1) |=> (int'(tmr_count) == int'($past(tmr_count)) - 1)); // R1
  AST_TC_ONE_SOLID: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && time_const == 1) |=> tmr_tick); // R3
  AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tx_clk_en |-> (tmr_tick && tx_div_pulse)); // R4
  AST_RX_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    rx_clk_en |-> (tmr_tick && rx_div_pulse)); // R4
  AST_TX_EXP0_PASS: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && tx_exp == 0 && tx_src == SRC_INTERNAL) |-> tx_clk_en); // R5
  AST_RX_EXP0_PASS: assert property (@(posedge clk) disable iff (rst)
    (tmr_tick && rx_exp == 0 && rx_src == SRC_INTERNAL) |-> rx_clk_en); // R5
  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    (tx_src != SRC_INTERNAL) |-> !tx_clk_en); // R8
  AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
    (rx_src != SRC_INTERNAL) |-> !rx_clk_en); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (tmr_count == 0 && !tx_clk_en && !rx_clk_en)); // R9
endmodule

bind dual_baud_gen dual_baud_gen_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .time_const   (time_const),
  .tx_exp       (tx_exp),
  .rx_exp       (rx_exp),
  .tx_src       (tx_src),
  .rx_src       (rx_src),
  .tx_clk_en    (tx_clk_en),
  .rx_clk_en    (rx_clk_en),
  .tmr_tick     (tmr_tick),
  .tmr_count    (tmr_count),
  .tx_div_pulse (tx_div_pulse),
  .rx_div_pulse (rx_div_pulse)
);

// File: tb/dual_baud_gen_test.sv
module dual_baud_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int WATCHDOG = 60000;
  // {time_const, tx_exp, rx_exp, tx_src, rx_src}
  localparam logic [21:0] VEC [NVEC] = '{
    {8'd5,   4'd0,  4'd2, 3'd2, 3'd2},
    {8'd1,   4'd0,  4'd3, 3'd2, 3'd2},
    {8'd3,   4'd4,  4'd1, 3'd2, 3'd2},
    {8'd7,   4'd2,  4'd0, 3'd2, 3'd5},
    {8'd2,   4'd15, 4'd9, 3'd2, 3'd2},
    {8'd0,   4'd0,  4'd1, 3'd2, 3'd2},
    {8'd255, 4'd1,  4'd0, 3'd0, 3'd2}
  };

  logic       clk = 0;
  logic       rst = 1;
  logic [7:0] time_const = 8'd5;
  logic [3:0] tx_exp = 0, rx_exp = 0;
  logic [2:0] tx_src = 3'd2, rx_src = 3'd2;
  logic       tx_clk_en, rx_clk_en;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_baud_gen uut (
    .clk(clk), .rst(rst), .time_const(time_const),
    .tx_exp(tx_exp), .rx_exp(rx_exp), .tx_src(tx_src), .rx_src(rx_src),
    .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_req(input int i);
    case (i)
      0: return "R1 R4 R5";
      1: return "R3 R5";
      2: return "R4";
      3: return "R8";
      4: return "R6";
      5: return "R2";
      default: return "R8";
    endcase
  endfunction

  function automatic int interval(input logic [7:0] tc);
    return (tc == 8'd0) ? 256 : int'(tc);
  endfunction

  function automatic int ratio(input logic [3:0] e);
    int k = (int'(e) >= 9) ? 9 : int'(e);
    return 1 << k;
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic run_case(input string req, input logic [7:0] tc, input logic [3:0] te, re,
                          input logic [2:0] ts, rs, input int cycles,
                          input int chg_at, input logic [7:0] chg_tc);
    int next_t, ticks, bad_tx, bad_rx, n_tx, n_rx, e_tx, e_rx;
    bit tick_now, want_tx, want_rx;
    @(negedge clk);
    rst = 1; time_const = tc; tx_exp = te; rx_exp = re; tx_src = ts; rx_src = rs;
    @(posedge clk); @(negedge clk);
    // R9: both enables low while reset is held
    check({"R9 reset ", req}, !tx_clk_en && !rx_clk_en, {tx_clk_en, rx_clk_en}, 0);
    @(posedge clk); @(negedge clk);
    rst = 0;
    next_t = interval(tc);
    ticks = 0; bad_tx = 0; bad_rx = 0; n_tx = 0; n_rx = 0; e_tx = 0; e_rx = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(posedge clk); @(negedge clk);
      tick_now = (k == next_t);
      if (tick_now) begin
        ticks++;
        next_t = next_t + interval(time_const);
      end
      want_tx = tick_now && (ticks % ratio(te) == 0) && (ts == 3'd2);
      want_rx = tick_now && (ticks % ratio(re) == 0) && (rs == 3'd2);
      if (tx_clk_en !== want_tx) bad_tx++;
      if (rx_clk_en !== want_rx) bad_rx++;
      n_tx += int'(tx_clk_en); n_rx += int'(rx_clk_en);
      e_tx += int'(want_tx);   e_rx += int'(want_rx);
      if (k == chg_at) time_const = chg_tc;
    end
    check({req, " tx pulses"}, bad_tx == 0, n_tx, e_tx);
    check({req, " rx pulses"}, bad_rx == 0, n_rx, e_rx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state at the ports
    check("R9 initial", !tx_clk_en && !rx_clk_en, {tx_clk_en, rx_clk_en}, 0);
    for (int i = 0; i < NVEC; i++) begin
      int pt, pr, cyc;
      pt = interval(VEC[i][21:14]) * ratio(VEC[i][13:10]);
      pr = interval(VEC[i][21:14]) * ratio(VEC[i][9:6]);
      cyc = 3 * ((pt > pr) ? pt : pr) + 2;
      run_case(vec_req(i), VEC[i][21:14], VEC[i][13:10], VEC[i][9:6],
               VEC[i][5:3], VEC[i][2:0], cyc, 0, 8'd0);
    end
    // R7: constant changed from 10 to 4 after edge 3; ticks expected at 10, 14, 18, 22
    run_case("R7", 8'd10, 4'd0, 4'd1, 3'd2, 3'd2, 26, 3, 8'd4);
    // R6 with R3: exponent 12 against 9 at full tick rate
    run_case("R6 R3", 8'd1, 4'd12, 4'd9, 3'd2, 3'd2, 1540, 0, 8'd0);
    // R9: reset in the middle of a run, then restart from the beginning
    run_case("R9 restart", 8'd4, 4'd1, 4'd2, 3'd2, 3'd2, 7, 0, 8'd0);
    run_case("R9 restart", 8'd4, 4'd1, 4'd2, 3'd2, 3'd2, 40, 0, 8'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule